// File: doc/BRIEF.md
# Priority Protection Permission Checker

This block decides whether a single memory access may proceed. It receives the access (start address, size in bytes, the requested read/write/execute mask and whether the requester runs in machine mode). It also receives a set of N already-decoded protection entries, each given as an inclusive byte range with an enable, a lock flag and its own read/write/execute bits. From these it returns a grant decision, the permission mask that applied and the index of the entry that decided.

Entries are scanned from index 0 upward. The first enabled entry that touches the access settles the outcome. An access that is only partly inside that entry is refused outright. Two policy inputs change the rules. A lockdown policy replaces the classic permission rules with a fixed 16-way table keyed by the entry's lock and permission bits. A whitelist policy refuses every access that no entry covers. The decision logic is combinational, and a parameter places an output register after it.

Top module: `prio_perm_checker`

## Requirements
- R1: The last byte of an access is `acc_addr + acc_size - 1`. Among enabled entries whose range contains the first or the last byte, the one with the lowest index decides. When that entry contains both bytes it is a match, and `chk_index` reports its index.
- R2: If the deciding entry contains exactly one of the first and last bytes, the access is refused with `chk_allow` = 0 and `chk_index` equal to that entry, even when a higher entry covers the whole access.
- R3: An entry whose enable bit is 0 never decides, whatever its range.
- R4: Masks use bit 0 = read, bit 1 = write, bit 2 = execute. Without lockdown, a match gives machine mode 3'b111 when the entry is unlocked. It gives the entry's own bits to machine mode when the entry is locked, and to every other mode.
- R5: Under lockdown, a match in machine mode forms a key {lock, R, W, X} from the entry. Keys 2, 3 and 14 give read+write. Keys 9 and 10 give execute. Keys 11 and 13 give read+execute. Keys 12 and 15 give read. Every other key gives nothing.
- R6: Under lockdown, a match in a non-machine mode uses the same key. Keys 1, 10 and 11 give execute. Keys 2, 4 and 15 give read. Keys 3 and 6 give read+write. Key 5 gives read+execute. Key 7 gives all three. Every other key gives nothing.
- R7: With no deciding entry and the whitelist policy set, every access is refused with mask 0, machine mode included.
- R8: With no deciding entry, lockdown set and whitelist clear, a machine-mode request without execute is granted with mask 3'b011. Any other request is refused with mask 0.
- R9: With no deciding entry and neither policy set, machine mode is granted with mask 3'b111 and other modes are refused with mask 0. With no deciding entry, `chk_index` equals N.
- R10: On a match, the access is granted exactly when every requested bit is set in the applied mask.
- R11: With the output register enabled, results appear one clock after the access is presented. A synchronous active-high reset forces grant 0, mask 0 and index N.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst | input | 1 | Synchronous active-high reset |
| acc_addr | input | AW | First byte address of the access |
| acc_size | input | SZW | Access size in bytes (1 or more) |
| acc_req | input | 3 | Requested mask {X,W,R} |
| acc_mach | input | 1 | Requester is in machine mode |
| pol_lockdown | input | 1 | Lockdown policy active |
| pol_whitelist | input | 1 | Whitelist (deny by default) policy active |
| ent_lo | input | N*AW | Inclusive lower bound per entry, entry i at bits [i*AW +: AW] |
| ent_hi | input | N*AW | Inclusive upper bound per entry |
| ent_on | input | N | Entry enable |
| ent_lock | input | N | Entry lock flag |
| ent_perm | input | N*3 | Entry permission bits {X,W,R} per entry |
| chk_grant | output | 1 | Access allowed |
| chk_allow | output | 3 | Applied permission mask {X,W,R} |
| chk_index | output | IW | Deciding entry, or N when none decided |

## Verification
The two functions that meet in one cycle are the priority scan and the partial-coverage refusal. An access can straddle the end of a low entry while lying wholly inside a higher, permissive entry. The bench provokes this with an 8-byte access that crosses the top of entry 1 while entry 3 covers it fully. It judges that the low entry's refusal wins: no grant, mask 0, index 1. It also checks the other side of the same boundary, where an access ending exactly on the last byte of entry 1 is a normal match.

// File: rtl/pchk_pkg.sv
package pchk_pkg;

    // Permission mask: bit0 read, bit1 write, bit2 execute
    typedef logic [2:0] perm_t;

    localparam perm_t PM_NONE = 3'b000;
    localparam perm_t PM_R    = 3'b001;
    localparam perm_t PM_RW   = 3'b011;
    localparam perm_t PM_X    = 3'b100;
    localparam perm_t PM_RX   = 3'b101;
    localparam perm_t PM_ALL  = 3'b111;

    // Lockdown key is {lock, R, W, X}
    function automatic logic [3:0] lock_key(input logic lk, input perm_t p);
        return {lk, p[0], p[1], p[2]};
    endfunction

    function automatic perm_t lockdown_mach(input logic [3:0] k);
        perm_t m;
        case (k)
            4'd2, 4'd3, 4'd14: m = PM_RW;
            4'd9, 4'd10:       m = PM_X;
            4'd11, 4'd13:      m = PM_RX;
            4'd12, 4'd15:      m = PM_R;
            default:           m = PM_NONE;
        endcase
        return m;
    endfunction

    function automatic perm_t lockdown_other(input logic [3:0] k);
        perm_t m;
        case (k)
            4'd1, 4'd10, 4'd11: m = PM_X;
            4'd2, 4'd4, 4'd15:  m = PM_R;
            4'd3, 4'd6:         m = PM_RW;
            4'd5:               m = PM_RX;
            4'd7:               m = PM_ALL;
            default:            m = PM_NONE;
        endcase
        return m;
    endfunction

    function automatic logic covers(input perm_t have, input perm_t want);
        return (want & ~have) == PM_NONE;
    endfunction

endpackage

// File: rtl/pchk_span.sv
module pchk_span #(
    parameter int AW = 32
) (
    input  logic [AW-1:0] lo,
    input  logic [AW-1:0] hi,
    input  logic          on,
    input  logic [AW-1:0] first_b,
    input  logic [AW-1:0] last_b,
    output logic          full,
    output logic          part
);
    logic first_in;
    logic last_in;

    always_comb begin
        first_in = on && (first_b >= lo) && (first_b <= hi);
        last_in  = on && (last_b  >= lo) && (last_b  <= hi);
        full     = first_in && last_in;
        part     = first_in ^ last_in;
    end
endmodule

// File: rtl/pchk_pick.sv
module pchk_pick #(
    parameter int N  = 8,
    parameter int IW = 4
) (
    input  logic [N-1:0]  full_v,
    input  logic [N-1:0]  part_v,
    output logic [N-1:0]  sel,
    output logic          hit,
    output logic          partial,
    output logic [IW-1:0] idx
);
    logic found;

    always_comb begin
        sel     = '0;
        hit     = 1'b0;
        partial = 1'b0;
        idx     = IW'(N);
        found   = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (!found && (full_v[i] || part_v[i])) begin
                found   = 1'b1;
                sel[i]  = 1'b1;
                idx     = IW'(i);
                hit     = full_v[i];
                partial = part_v[i];
            end
        end
    end
endmodule

// File: rtl/pchk_judge.sv
module pchk_judge
    import pchk_pkg::*;
(
    input  logic  hit,
    input  logic  partial,
    input  logic  e_lock,
    input  perm_t e_perm,
    input  logic  mach,
    input  logic  lockdown,
    input  logic  whitelist,
    input  perm_t req,
    output logic  grant,
    output perm_t allow
);
    always_comb begin
        grant = 1'b0;
        allow = PM_NONE;
        if (partial) begin
            grant = 1'b0;
            allow = PM_NONE;
        end else if (hit) begin
            if (lockdown) begin
                allow = mach ? lockdown_mach(lock_key(e_lock, e_perm))
                             : lockdown_other(lock_key(e_lock, e_perm));
            end else begin
                allow = (mach && !e_lock) ? PM_ALL : e_perm;
            end
            grant = covers(allow, req);
        end else if (whitelist) begin
            grant = 1'b0;
            allow = PM_NONE;
        end else if (lockdown) begin
            if (mach && !req[2]) begin
                grant = 1'b1;
                allow = PM_RW;
            end
        end else if (mach) begin
            grant = 1'b1;
            allow = PM_ALL;
        end
    end
endmodule

// File: rtl/prio_perm_checker.sv
module prio_perm_checker
    import pchk_pkg::*;
#(
    parameter int N       = 8,
    parameter int AW      = 32,
    parameter int SZW     = 4,
    parameter bit REG_OUT = 1'b1,
    localparam int IW     = $clog2(N + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [AW-1:0]   acc_addr,
    input  logic [SZW-1:0]  acc_size,
    input  logic [2:0]      acc_req,
    input  logic            acc_mach,
    input  logic            pol_lockdown,
    input  logic            pol_whitelist,
    input  logic [N*AW-1:0] ent_lo,
    input  logic [N*AW-1:0] ent_hi,
    input  logic [N-1:0]    ent_on,
    input  logic [N-1:0]    ent_lock,
    input  logic [N*3-1:0]  ent_perm,
    output logic            chk_grant,
    output logic [2:0]      chk_allow,
    output logic [IW-1:0]   chk_index
);
    logic [AW-1:0] last_b;
    logic [N-1:0]  full_v;
    logic [N-1:0]  part_v;
    logic [N-1:0]  sel;
    logic          pk_hit;
    logic          pk_partial;
    logic [IW-1:0] pk_idx;
    logic          sel_lock;
    perm_t         sel_perm;
    logic          jd_grant;
    perm_t         jd_allow;

    assign last_b = acc_addr + AW'(acc_size) - AW'(1);

    for (genvar g = 0; g < N; g++) begin : g_span
        pchk_span #(.AW(AW)) u_span (
            .lo      (ent_lo[g*AW +: AW]),
            .hi      (ent_hi[g*AW +: AW]),
            .on      (ent_on[g]),
            .first_b (acc_addr),
            .last_b  (last_b),
            .full    (full_v[g]),
            .part    (part_v[g])
        );
    end

    pchk_pick #(.N(N), .IW(IW)) u_pick (
        .full_v  (full_v),
        .part_v  (part_v),
        .sel     (sel),
        .hit     (pk_hit),
        .partial (pk_partial),
        .idx     (pk_idx)
    );

    always_comb begin
        sel_lock = 1'b0;
        sel_perm = PM_NONE;
        for (int i = 0; i < N; i++) begin
            if (sel[i]) begin
                sel_lock = ent_lock[i];
                sel_perm = ent_perm[i*3 +: 3];
            end
        end
    end

    pchk_judge u_judge (
        .hit       (pk_hit),
        .partial   (pk_partial),
        .e_lock    (sel_lock),
        .e_perm    (sel_perm),
        .mach      (acc_mach),
        .lockdown  (pol_lockdown),
        .whitelist (pol_whitelist),
        .req       (acc_req),
        .grant     (jd_grant),
        .allow     (jd_allow)
    );

    if (REG_OUT) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                chk_grant <= 1'b0;
                chk_allow <= PM_NONE;
                chk_index <= IW'(N);
            end else begin
                chk_grant <= jd_grant;
                chk_allow <= jd_allow;
                chk_index <= pk_idx;
            end
        end

        // R11
        reg_latency_chk: assert property (@(posedge clk) disable iff (rst)
            1'b1 |=> (chk_grant == $past(jd_grant)) && (chk_index == $past(pk_idx)));
    end else begin : g_comb
        assign chk_grant = jd_grant;
        assign chk_allow = jd_allow;
        assign chk_index = pk_idx;
    end

    // R1
    first_win_chk: assert property (@(posedge clk) disable iff (rst)
        pk_hit |-> (((full_v | part_v) & ((N'(1) << pk_idx) - N'(1))) == '0));

    // R2
    partial_deny_chk: assert property (@(posedge clk) disable iff (rst)
        pk_partial |-> (!jd_grant && jd_allow == PM_NONE));

    // R7
    whitelist_deny_chk: assert property (@(posedge clk) disable iff (rst)
        (pol_whitelist && !pk_hit && !pk_partial) |-> !jd_grant);

    // R10
    grant_subset_chk: assert property (@(posedge clk) disable iff (rst)
        (pk_hit && jd_grant) |-> ((acc_req & ~jd_allow) == 3'b000));

    // R9
    none_index_chk: assert property (@(posedge clk) disable iff (rst)
        (!pk_hit && !pk_partial) |-> (pk_idx == IW'(N)));
endmodule

// File: tb/prio_perm_checker_bench.sv
module prio_perm_checker_bench;
    localparam int N   = 8;
    localparam int AW  = 32;
    localparam int SZW = 4;
    localparam int IW  = $clog2(N + 1);

    logic            clk = 1'b0;
    logic            rst;
    logic [AW-1:0]   acc_addr;
    logic [SZW-1:0]  acc_size;
    logic [2:0]      acc_req;
    logic            acc_mach;
    logic            pol_lockdown;
    logic            pol_whitelist;
    logic [N*AW-1:0] ent_lo;
    logic [N*AW-1:0] ent_hi;
    logic [N-1:0]    ent_on;
    logic [N-1:0]    ent_lock;
    logic [N*3-1:0]  ent_perm;
    logic            chk_grant;
    logic [2:0]      chk_allow;
    logic [IW-1:0]   chk_index;

    logic [AW-1:0] lo_a [N];
    logic [AW-1:0] hi_a [N];
    logic [2:0]    pm_a [N];

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    always_comb begin
        for (int i = 0; i < N; i++) begin
            ent_lo[i*AW +: AW] = lo_a[i];
            ent_hi[i*AW +: AW] = hi_a[i];
            ent_perm[i*3 +: 3] = pm_a[i];
        end
    end

    prio_perm_checker #(.N(N), .AW(AW), .SZW(SZW), .REG_OUT(1'b1)) u_prio_perm_checker (
        .clk(clk), .rst(rst), .acc_addr(acc_addr), .acc_size(acc_size),
        .acc_req(acc_req), .acc_mach(acc_mach), .pol_lockdown(pol_lockdown),
        .pol_whitelist(pol_whitelist), .ent_lo(ent_lo), .ent_hi(ent_hi),
        .ent_on(ent_on), .ent_lock(ent_lock), .ent_perm(ent_perm),
        .chk_grant(chk_grant), .chk_allow(chk_allow), .chk_index(chk_index)
    );

    task automatic expect_out(input string tag, input logic g, input logic [2:0] a,
                              input logic [IW-1:0] ix);
        checks++;
        if (chk_grant !== g || chk_allow !== a || chk_index !== ix) begin
            fails++;
            $display("FAIL %s: got grant=%0b allow=%03b index=%0d, expected grant=%0b allow=%03b index=%0d",
                     tag, chk_grant, chk_allow, chk_index, g, a, ix);
        end
    endtask

    // Drive at the falling edge, registered at the next rising edge, sampled at the falling edge after
    task automatic access(input logic [AW-1:0] ad, input int sz, input logic [2:0] rq,
                          input logic m);
        @(negedge clk);
        acc_addr = ad;
        acc_size = SZW'(sz);
        acc_req  = rq;
        acc_mach = m;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic clear_all();
        @(negedge clk);
        for (int i = 0; i < N; i++) begin
            lo_a[i] = '0;
            hi_a[i] = '0;
            pm_a[i] = 3'b000;
        end
        ent_on        = '0;
        ent_lock      = '0;
        pol_lockdown  = 1'b0;
        pol_whitelist = 1'b0;
        // entry layout used by all scenarios
        lo_a[0] = 32'h1000; hi_a[0] = 32'h10FF;
        lo_a[1] = 32'h2000; hi_a[1] = 32'h20FF;
        lo_a[2] = 32'h3000; hi_a[2] = 32'h30FF;
        lo_a[3] = 32'h2000; hi_a[3] = 32'h2FFF;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        clear_all();
        acc_addr = 32'h3000; acc_size = 4; acc_req = 3'b001; acc_mach = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        expect_out("R11 reset state", 1'b0, 3'b000, IW'(N));
        rst = 1'b0;
    endtask

    task automatic t_classic();
        clear_all();
        ent_on[2] = 1'b1; pm_a[2] = 3'b001;
        access(32'h3010, 4, 3'b001, 1'b0);
        expect_out("R4 R10 user read on R entry", 1'b1, 3'b001, IW'(2));
        access(32'h3010, 4, 3'b010, 1'b0);
        expect_out("R10 user write on R entry", 1'b0, 3'b001, IW'(2));
        access(32'h3010, 4, 3'b010, 1'b1);
        expect_out("R4 machine unlocked full", 1'b1, 3'b111, IW'(2));
        @(negedge clk); ent_lock[2] = 1'b1;
        access(32'h3010, 4, 3'b010, 1'b1);
        expect_out("R4 machine locked uses entry bits", 1'b0, 3'b001, IW'(2));
    endtask

    task automatic t_priority();
        clear_all();
        ent_on[1] = 1'b1; pm_a[1] = 3'b001;
        ent_on[3] = 1'b1; pm_a[3] = 3'b111;
        access(32'h2040, 4, 3'b010, 1'b0);
        expect_out("R1 lower entry wins", 1'b0, 3'b001, IW'(1));
        access(32'h2800, 4, 3'b010, 1'b0);
        expect_out("R1 higher entry only", 1'b1, 3'b111, IW'(3));
        access(32'h20F8, 8, 3'b001, 1'b0);
        expect_out("R1 access ends on last byte", 1'b1, 3'b001, IW'(1));
        access(32'h20FC, 8, 3'b001, 1'b0);
        expect_out("R2 straddle beats higher cover", 1'b0, 3'b000, IW'(1));
        access(32'h1FFE, 4, 3'b001, 1'b1);
        expect_out("R2 straddle start machine", 1'b0, 3'b000, IW'(1));
    endtask

    task automatic t_disabled();
        clear_all();
        pm_a[0] = 3'b111;
        access(32'h1000, 1, 3'b001, 1'b0);
        expect_out("R3 R9 disabled entry user", 1'b0, 3'b000, IW'(N));
        access(32'h1000, 1, 3'b111, 1'b1);
        expect_out("R3 R9 disabled entry machine", 1'b1, 3'b111, IW'(N));
    endtask

    task automatic t_whitelist();
        clear_all();
        pol_whitelist = 1'b1;
        access(32'h9000, 4, 3'b001, 1'b1);
        expect_out("R7 whitelist machine", 1'b0, 3'b000, IW'(N));
        @(negedge clk); pol_lockdown = 1'b1;
        access(32'h9000, 2, 3'b001, 1'b1);
        expect_out("R7 whitelist with lockdown", 1'b0, 3'b000, IW'(N));
    endtask

    task automatic t_lock_default();
        clear_all();
        pol_lockdown = 1'b1;
        access(32'h9000, 4, 3'b011, 1'b1);
        expect_out("R8 machine data", 1'b1, 3'b011, IW'(N));
        access(32'h9000, 4, 3'b100, 1'b1);
        expect_out("R8 machine execute", 1'b0, 3'b000, IW'(N));
        access(32'h9000, 4, 3'b001, 1'b0);
        expect_out("R8 user", 1'b0, 3'b000, IW'(N));
    endtask

    task automatic t_lock_table();
        clear_all();
        pol_lockdown = 1'b1;
        ent_on[2] = 1'b1;
        // key 9: L=1 X=1
        ent_lock[2] = 1'b1; pm_a[2] = 3'b100;
        access(32'h3000, 4, 3'b100, 1'b1);
        expect_out("R5 key 9", 1'b1, 3'b100, IW'(2));
        // key 14: L R W
        @(negedge clk); pm_a[2] = 3'b011;
        access(32'h3000, 4, 3'b010, 1'b1);
        expect_out("R5 key 14", 1'b1, 3'b011, IW'(2));
        // key 5: R X unlocked
        @(negedge clk); ent_lock[2] = 1'b0; pm_a[2] = 3'b101;
        access(32'h3000, 4, 3'b001, 1'b1);
        expect_out("R5 key 5", 1'b0, 3'b000, IW'(2));
        access(32'h3000, 4, 3'b101, 1'b0);
        expect_out("R6 key 5", 1'b1, 3'b101, IW'(2));
        // key 7: R W X unlocked
        @(negedge clk); pm_a[2] = 3'b111;
        access(32'h3000, 4, 3'b010, 1'b0);
        expect_out("R6 key 7", 1'b1, 3'b111, IW'(2));
        // key 10: L W
        @(negedge clk); ent_lock[2] = 1'b1; pm_a[2] = 3'b010;
        access(32'h3000, 4, 3'b100, 1'b0);
        expect_out("R6 key 10", 1'b1, 3'b100, IW'(2));
        // key 15
        @(negedge clk); pm_a[2] = 3'b111;
        access(32'h3000, 4, 3'b010, 1'b0);
        expect_out("R6 key 15", 1'b0, 3'b001, IW'(2));
        access(32'h3000, 4, 3'b001, 1'b1);
        expect_out("R5 key 15", 1'b1, 3'b001, IW'(2));
    endtask

    initial begin
        t_reset();
        t_classic();
        t_priority();
        t_disabled();
        t_whitelist();
        t_lock_default();
        t_lock_table();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got no completion, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule